// File: doc/BRIEF.md
# Serial Two-Wire Byte Memory Target with Upper-Half Write Lock

This block is an I2C target that fronts a 512-byte memory. A bus master can write single bytes or runs of consecutive bytes. It can read from the current address, from a random address (set with a write header followed by a repeated START), or read a run of consecutive bytes. The block runs on a system clock. It brings SCL and SDA in through two-flop synchronisers and finds bus edges and START/STOP conditions from the synchronised copies. On SDA it only ever pulls low or lets go.

Two strap inputs give the expected values of two bits of the select byte, so that up to four such targets can share one bus. A write-lock input guards the upper half of the array, addresses 100h to 1FFh. While the lock is high, the select and address bytes of a write aimed there are still acknowledged, but each data byte is refused and is not stored. Reads and lower-half writes never depend on the lock.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The select byte is, MSB first, `1010`, strap_hi, strap_lo, address bit 8, R/W (1 = read). The block acknowledges it only when the top nibble is 1010, bit 3 equals strap_hi and bit 2 equals strap_lo. On a mismatch it leaves SDA released until the next START.
- R2: A write is a select byte with bit 0 = 0 and bit 1 = address bit 8, then a byte holding address bits 7..0, then data bytes. Each data byte is stored at the address counter, and every byte is acknowledged by pulling SDA low in the ninth clock.
- R3: When wr_lock is 1 and the address counter is 100h or above, a data byte is not stored and SDA stays released in its ninth clock. The select and address bytes of the same transfer are still acknowledged.
- R4: With wr_lock at 0, the whole array is writable. Whatever the level of wr_lock, lower-half writes and all reads behave normally.
- R5: The address counter advances by one after every data byte (stored, refused or read) and wraps from 1FFh to 000h. The lock check is made again for each data byte against the current counter.
- R6: A select byte with bit 0 = 1 returns the byte at the address counter, MSB first, and ignores select bit 1. A write header followed by a repeated START sets the counter for a random read.
- R7: During a read, an ACK from the master (SDA low in the ninth clock) makes the block send the next byte. A NACK makes it release SDA and stay silent until the next START or STOP.
- R8: A START at any point discards the byte in progress and waits for a select byte. A STOP at any point returns to idle. A partial byte changes neither the memory nor the counter.
- R9: sda_pull_o = 1 means SDA is pulled low. It is 0 after reset, and it is asserted only while the synchronised SCL is low. Received bits are taken on the synchronised rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_hi | input | 1 | Expected value of select-byte bit 3 |
| strap_lo | input | 1 | Expected value of select-byte bit 2 |
| wr_lock | input | 1 | 1 refuses writes to addresses 100h-1FFh |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Write runs that start at 0FEh with the lock high. If the lock check were made once per transfer rather than once per byte, the refusal would not begin exactly at 100h.
- Runs that cross 1FFh. A counter that failed to wrap, or that skipped refused bytes, would read back data from the wrong place.
- START and STOP issued in the middle of a select, address or data byte. Any leftover bit count or early memory write would show up as a wrong acknowledge or corrupted data.
- Select bytes with a mismatched strap bit, and reads ended by a NACK. In both cases the bench clocks the bus further and checks that SDA is never pulled.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  localparam int EE_AW    = 9;
  localparam int EE_DEPTH = 1 << EE_AW;
  localparam int EE_DW    = 8;
  localparam logic [3:0] EE_TYPE_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_t;

  // select byte: type nibble, two strap bits, address bit 8, read flag
  function automatic logic sel_hit(input logic [7:0] sel, input logic s_hi,
                                   input logic s_lo);
    return (sel[7:4] == EE_TYPE_ID) && (sel[3] == s_hi) && (sel[2] == s_lo);
  endfunction

  function automatic logic [EE_AW-1:0] addr_step(input logic [EE_AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic wr_blocked(input logic lock, input logic [EE_AW-1:0] a);
    return lock & a[EE_AW-1];
  endfunction

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_d;
  logic              sda_d;

  // bus idles high, so the chain resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             strap_hi,
  input  logic             strap_lo,
  input  logic             wr_lock,
  input  logic [EE_DW-1:0] rd_data,
  output logic             mem_we,
  output logic [EE_DW-1:0] mem_wdata,
  output logic [EE_AW-1:0] cur_addr,
  output logic             sda_pull,
  output ee_state_t        state_o,
  output logic [3:0]       bitcnt_o,
  output logic             byte_done,
  output logic             blocked
);

  ee_state_t        state_q, nxt_q;
  logic [3:0]       bitcnt_q;
  logic [7:0]       sh_q;
  logic [7:0]       tx_q;
  logic [EE_AW-1:0] addr_q;
  logic             a8_q;
  logic             ack_q;
  logic             mack_q;

  logic [7:0] byte_in;
  logic       rx_state;
  logic       data_phase;
  logic       lock_hit;

  assign byte_in    = {sh_q[6:0], sda_s};
  assign rx_state   = (state_q == ST_DEV) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
  assign byte_done  = rx_state && scl_rise && (bitcnt_q == 4'd7);
  assign data_phase = (state_q == ST_WDATA);
  assign lock_hit   = wr_blocked(wr_lock, addr_q);
  assign blocked    = byte_done && data_phase && lock_hit;
  assign mem_we     = byte_done && data_phase && !lock_hit;
  assign mem_wdata  = byte_in;
  assign cur_addr   = addr_q;
  assign state_o    = state_q;
  assign bitcnt_o   = bitcnt_q;

  assign sda_pull = ((state_q == ST_ACK) && ack_q) ||
                    ((state_q == ST_RDATA) && !tx_q[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      bitcnt_q <= 4'd0;
      sh_q     <= 8'd0;
      tx_q     <= 8'hFF;
      addr_q   <= '0;
      a8_q     <= 1'b0;
      ack_q    <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_DEV;
      bitcnt_q <= 4'd0;
      ack_q    <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= 4'd0;
      ack_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && (bitcnt_q != 4'd8)) begin
            sh_q     <= byte_in;
            bitcnt_q <= bitcnt_q + 4'd1;
          end
          if (byte_done) begin
            case (state_q)
              ST_DEV: begin
                if (sel_hit(byte_in, strap_hi, strap_lo)) begin
                  ack_q <= 1'b1;
                  if (byte_in[0]) begin
                    nxt_q <= ST_RDATA;
                  end else begin
                    nxt_q <= ST_ADDR;
                    a8_q  <= byte_in[1];
                  end
                end else begin
                  ack_q <= 1'b0;
                  nxt_q <= ST_IDLE;
                end
              end
              ST_ADDR: begin
                addr_q <= {a8_q, byte_in};
                ack_q  <= 1'b1;
                nxt_q  <= ST_WDATA;
              end
              default: begin
                ack_q  <= !lock_hit;
                nxt_q  <= ST_WDATA;
                addr_q <= addr_step(addr_q);
              end
            endcase
          end
          if (scl_fall && (bitcnt_q == 4'd8)) begin
            state_q  <= ST_ACK;
            bitcnt_q <= 4'd0;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_q  <= nxt_q;
            ack_q    <= 1'b0;
            bitcnt_q <= 4'd0;
            if (nxt_q == ST_RDATA) begin
              tx_q   <= rd_data;
              addr_q <= addr_step(addr_q);
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) bitcnt_q <= bitcnt_q + 4'd1;
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              state_q  <= ST_RACK;
              bitcnt_q <= 4'd0;
              mack_q   <= 1'b0;
            end else begin
              tx_q <= {tx_q[6:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= !sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_RDATA;
              tx_q    <= rd_data;
              addr_q  <= addr_step(addr_q);
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  input  logic strap_hi,
  input  logic strap_lo,
  input  logic wr_lock
);

  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             mem_we, byte_done, blocked, sda_pull;
  logic [EE_DW-1:0] mem_wdata, rd_data;
  logic [EE_AW-1:0] cur_addr;
  logic [3:0]       bitcnt;
  ee_state_t        ee_state;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_ee_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap_hi (strap_hi),
    .strap_lo (strap_lo),
    .wr_lock  (wr_lock),
    .rd_data  (rd_data),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .cur_addr (cur_addr),
    .sda_pull (sda_pull),
    .state_o  (ee_state),
    .bitcnt_o (bitcnt),
    .byte_done(byte_done),
    .blocked  (blocked)
  );

  i2c_ee_mem #(.DEPTH(EE_DEPTH), .DW(EE_DW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(cur_addr),
    .wdata(mem_wdata),
    .raddr(cur_addr),
    .rdata(rd_data)
  );

  assign sda_pull_o = sda_pull;

endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
  import i2c_ee_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_pull,
  input logic             mem_we,
  input logic             blocked,
  input logic             byte_done,
  input logic [EE_AW-1:0] cur_addr,
  input ee_state_t        state,
  input logic [3:0]       bitcnt
);

  ee_state_t prev_state;
  logic      blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_state <= ST_IDLE;
      blk_q      <= 1'b0;
    end else begin
      prev_state <= state;
      if (blocked) blk_q <= 1'b1;
      else if ((prev_state == ST_ACK && state != ST_ACK) || start_det || stop_det)
        blk_q <= 1'b0;
    end
  end

  assert_start_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && bitcnt == 4'd0));

  assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_pull));

  assert_blocked_no_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (!mem_we && byte_done));

  assert_blocked_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && state == ST_ACK) |-> !sda_pull);

  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_we) || $past(blocked)) |->
      (($past(cur_addr) == {EE_AW{1'b1}}) ? (cur_addr == '0)
                                          : (cur_addr > $past(cur_addr))));

endmodule

bind i2c_eeprom_target i2c_ee_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_pull (sda_pull),
  .mem_we   (mem_we),
  .blocked  (blocked),
  .byte_done(byte_done),
  .cur_addr (cur_addr),
  .state    (ee_state),
  .bitcnt   (bitcnt)
);

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap_hi = 1'b1;
  logic strap_lo = 1'b0;
  logic wr_lock = 1'b0;
  logic sda_pull;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int exp_addr = 0;
  bit finished = 0;
  logic [7:0] bm [512];
  bit kn [512];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_eeprom_target uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_pull_o(sda_pull),
    .strap_hi  (strap_hi),
    .strap_lo  (strap_lo),
    .wr_lock   (wr_lock)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sel_byte(input bit a8, input bit rd, input bit bad);
    return {4'b1010, strap_hi ^ bad, strap_lo, a8, rd};
  endfunction

  function automatic int next_a(input int a);
    return (a == 511) ? 0 : a + 1;
  endfunction

  task automatic do_start;
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic do_stop;
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = !sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b = {b[6:0], sda_bus}; wq(Q);
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = !mack; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  // clocks the bus with SDA released and counts cycles where the target pulls
  task automatic quiet_clocks(input string req);
    int pulls = 0;
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wq(Q);
      scl_m = 1'b1;
      for (int k = 0; k < 2 * Q; k++) begin wq(1); if (sda_pull) pulls++; end
      scl_m = 1'b0;
      for (int k = 0; k < Q; k++) begin wq(1); if (sda_pull) pulls++; end
    end
    check(pulls == 0, req, pulls, 0);
  endtask

  task automatic write_burst(input int a, input int n);
    bit ack, ok;
    logic [7:0] d;
    do_start;
    send_byte(sel_byte(a[8], 1'b0, 1'b0), ack);
    check(ack, "R2/R3 write select ack", ack, 1);
    send_byte(a[7:0], ack);
    check(ack, "R2/R3 address ack", ack, 1);
    exp_addr = a;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      ok = !(wr_lock && exp_addr[8]);
      send_byte(d, ack);
      check(ack == ok, ok ? "R2/R4 data ack" : "R3 refused data", ack, ok);
      if (ok) begin bm[exp_addr] = d; kn[exp_addr] = 1; end
      exp_addr = next_a(exp_addr);
    end
    do_stop;
  endtask

  task automatic read_run(input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      if (kn[exp_addr]) check(d == bm[exp_addr], "R6/R7/R5 read data", d, bm[exp_addr]);
      exp_addr = next_a(exp_addr);
    end
  endtask

  task automatic read_rand(input int a, input int n);
    bit ack;
    do_start;
    send_byte(sel_byte(a[8], 1'b0, 1'b0), ack);
    send_byte(a[7:0], ack);
    exp_addr = a;
    do_start;
    send_byte(sel_byte(1'b0, 1'b1, 1'b0), ack);
    check(ack, "R6 read select ack", ack, 1);
    read_run(n);
    do_stop;
  endtask

  task automatic read_cur(input int n);
    bit ack;
    do_start;
    send_byte(sel_byte(~exp_addr[8], 1'b1, 1'b0), ack);
    check(ack, "R6 current read select ack", ack, 1);
    read_run(n);
    do_stop;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit ack;
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    wq(5);
    check(sda_pull == 1'b0, "R9 released in reset", sda_pull, 0);
    rst_n = 1'b1;
    wq(5);
    check(sda_pull == 1'b0, "R9 released after reset", sda_pull, 0);

    // basic write and random read, lower half
    write_burst(12'h010, 4);
    read_rand(12'h010, 4);
    read_cur(1);

    // wrong strap: no ack, bus stays quiet
    do_start;
    send_byte(sel_byte(1'b0, 1'b0, 1'b1), ack);
    check(!ack, "R1 mismatched select", ack, 0);
    quiet_clocks("R1 silent after mismatch");
    do_stop;
    strap_lo = 1'b1;
    write_burst(12'h020, 2);
    read_rand(12'h020, 2);
    strap_lo = 1'b0;

    // lock: upper half refused, lower half and reads unaffected
    write_burst(12'h180, 4);
    wr_lock = 1'b1;
    write_burst(12'h180, 4);
    read_rand(12'h180, 4);
    write_burst(12'h0FE, 4);
    read_rand(12'h0FE, 4);
    write_burst(12'h030, 2);
    read_rand(12'h030, 2);
    wr_lock = 1'b0;

    // wrap at top of array
    write_burst(12'h1FE, 4);
    read_rand(12'h1FF, 3);
    read_cur(2);

    // aborts
    write_burst(12'h040, 2);
    do_start;
    send_byte(sel_byte(1'b0, 1'b0, 1'b0), ack);
    send_byte(8'h40, ack);
    exp_addr = 12'h040;
    do_start;
    send_bits(8'hA0, 4);
    do_start;
    send_byte(sel_byte(1'b0, 1'b1, 1'b0), ack);
    check(ack, "R8 select after START abort", ack, 1);
    recv_byte(1'b0, d);
    check(d == bm[12'h040], "R8 data after START abort", d, bm[12'h040]);
    exp_addr = 12'h041;
    do_stop;
    do_start;
    send_byte(sel_byte(1'b1, 1'b0, 1'b0), ack);
    send_bits(8'h33, 5);
    do_stop;
    read_cur(1);
    do_start;
    send_byte(sel_byte(1'b0, 1'b0, 1'b0), ack);
    send_byte(8'h41, ack);
    send_bits(8'hFF, 6);
    do_stop;
    read_rand(12'h041, 1);

    // NACK ends read
    do_start;
    send_byte(sel_byte(1'b0, 1'b1, 1'b0), ack);
    read_run(1);
    quiet_clocks("R7 released after NACK");
    do_stop;

    // constrained random traffic
    for (int it = 0; it < 40; it++) begin
      int op, base, a;
      op = int'($urandom_range(0, 3));
      base = int'($urandom_range(0, 2));
      a = (base == 0) ? int'($urandom_range(0, 511)) :
          (base == 1) ? 12'h0FC + int'($urandom_range(0, 5)) :
                        12'h1FC + int'($urandom_range(0, 3));
      case (op)
        0: write_burst(a, int'($urandom_range(1, 4)));
        1: read_rand(a, int'($urandom_range(1, 4)));
        2: read_cur(int'($urandom_range(1, 3)));
        default: wr_lock = 1'($urandom_range(0, 1));
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule